// File: doc/BRIEF.md
# Component Swizzle Mask Generator

This block prepares the per-byte selector table that a copy engine's remap stage uses to build each destination pixel. It takes a 32-bit format word, an X element count and two 32-bit constant values. From these it produces a 16-entry byte table in which each entry names one byte of the source pixel, one byte of either constant, or a forced zero. It also produces the bytes moved per line on the source and destination sides, and a packed word that holds the pixel sizes minus one.

A start pulse captures the inputs. The table is then cleared, and a walker visits one table position per cycle across a fixed sixteen-step window. Destination components are visited in ascending order, and within each component the bytes are visited in ascending order. The line counts and the size word are computed in one final cycle, and a one-cycle done pulse follows. The results stay unchanged until the next accepted start. The block does not move any pixel data.

Top module: `swz_mask_gen`

## Requirements
- R1: While reset is asserted and after it is released, done, busy, all four selector words, both line counts and the size word read zero.
- R2: Bytes per component are format bits 17:16 plus one. Source component count is bits 21:20 plus one. Destination component count is bits 25:24 plus one. Destination component i takes its 4-bit selector from bits 4i+3:4i. All other format bits have no effect.
- R3: For a selector value of 0 to 3, the table byte is selector times bytes-per-component plus the byte index within the component.
- R4: Selector 4 gives 0x10 plus the byte index, which addresses the first constant. Selector 5 gives 0x14 plus the byte index, which addresses the second constant.
- R5: Any selector value from 6 to 15 gives the zero-fill code 0x80.
- R6: Table byte k is written for component k / bpc and byte k % bpc. Byte k appears on selector word k/4 at bits 8(k%4)+7:8(k%4). Positions at or beyond components × bpc read zero.
- R7: The size word holds (bpc × destination components − 1) at bits 15:8 and (bpc × source components − 1) at bits 7:0. Bits 31:16 are zero.
- R8: The destination line count is x_count × bpc × destination components. The source line count is x_count × bpc × source components, but it is zero when no used component has a selector below 4.
- R9: An accepted start leads to a done pulse lasting exactly one cycle, 17 cycles later. Busy stays high from the cycle after the start until done rises. A start that arrives while busy is ignored.
- R10: The constant outputs present the constant inputs captured with the accepted start.
- R11: While idle with no start, every result output holds its value even if the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation (accepted when idle) |
| fmt_word | input | 32 | Format word: selectors, component size and counts |
| x_count | input | XCNT_W | Elements per line |
| const_a | input | 32 | First constant value |
| const_b | input | 32 | Second constant value |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse when results are ready |
| sel_w0 | output | 32 | Table bytes 3..0 |
| sel_w1 | output | 32 | Table bytes 7..4 |
| sel_w2 | output | 32 | Table bytes 11..8 |
| sel_w3 | output | 32 | Table bytes 15..12 |
| src_line_bytes | output | XCNT_W+5 | Source bytes per line |
| dst_line_bytes | output | XCNT_W+5 | Destination bytes per line |
| size_word | output | 32 | Packed pixel sizes minus one |
| const_a_out | output | 32 | Captured first constant |
| const_b_out | output | 32 | Captured second constant |

## Verification
The assertions rely on start being the only thing that can begin a computation. They also rely on the selector codes being limited to byte offsets below 0x18 and the zero code, which follows from bytes-per-component being at most four. The stimulus sweeps every combination of component size, source count and destination count. For each combination it applies every selector value, both uniformly and in rotated mixes, with unrelated format bits filled with pseudo-random data. A few runs raise start again in mid-computation with altered inputs, to confirm that the captured operands win.

// File: rtl/swz_pkg.sv
package swz_pkg;

  localparam logic [7:0] CODE_CONST_A = 8'h10;
  localparam logic [7:0] CODE_CONST_B = 8'h14;
  localparam logic [7:0] CODE_ZERO    = 8'h80;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_FIN  = 2'd2
  } walk_state_t;

  typedef struct packed {
    logic [2:0] bpc;
    logic [2:0] nsrc;
    logic [2:0] ndst;
  } fmt_fields_t;

  function automatic fmt_fields_t decode_fmt(input logic [31:0] f);
    fmt_fields_t r;
    r.bpc  = {1'b0, f[17:16]} + 3'd1;
    r.nsrc = {1'b0, f[21:20]} + 3'd1;
    r.ndst = {1'b0, f[25:24]} + 3'd1;
    return r;
  endfunction

endpackage

// File: rtl/swz_byte_enc.sv
module swz_byte_enc
  import swz_pkg::*;
(
  input  logic [3:0] sel,
  input  logic [2:0] bpc,
  input  logic [2:0] byte_i,
  output logic [7:0] code,
  output logic       src_hit
);
  always_comb begin
    src_hit = (sel < 4'd4);
    if (sel < 4'd4) begin
      code = 8'(sel[1:0]) * 8'(bpc) + 8'(byte_i);
    end else if (sel == 4'd4) begin
      code = CODE_CONST_A + 8'(byte_i);
    end else if (sel == 4'd5) begin
      code = CODE_CONST_B + 8'(byte_i);
    end else begin
      code = CODE_ZERO;
    end
  end
endmodule

// File: rtl/swz_walker.sv
module swz_walker
  import swz_pkg::*;
#(
  parameter int SEL_BYTES = 16,
  parameter int IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [2:0]       bpc,
  input  logic [2:0]       ndst,
  output logic             busy,
  output logic             accept,
  output logic             step_en,
  output logic             fin,
  output logic             done,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W:0]   comp,
  output logic [2:0]       byte_i
);
  walk_state_t st;
  logic        last_idx;
  logic        last_byte;

  assign busy      = (st != ST_IDLE);
  assign accept    = start && (st == ST_IDLE);
  assign fin       = (st == ST_FIN);
  assign last_idx  = (idx == IDX_W'(SEL_BYTES - 1));
  assign last_byte = ((byte_i + 3'd1) == bpc);
  assign step_en   = (st == ST_WALK) && (comp < (IDX_W+1)'(ndst));

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      idx    <= '0;
      comp   <= '0;
      byte_i <= '0;
      done   <= 1'b0;
    end else begin
      done <= (st == ST_FIN);
      case (st)
        ST_IDLE: begin
          if (start) begin
            st     <= ST_WALK;
            idx    <= '0;
            comp   <= '0;
            byte_i <= '0;
          end
        end
        ST_WALK: begin
          idx <= idx + 1'b1;
          if (last_byte) begin
            byte_i <= '0;
            comp   <= comp + 1'b1;
          end else begin
            byte_i <= byte_i + 3'd1;
          end
          if (last_idx) st <= ST_FIN;
        end
        ST_FIN:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swz_sel_store.sv
module swz_sel_store #(
  parameter int SEL_BYTES = 16,
  parameter int IDX_W     = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   we,
  input  logic [IDX_W-1:0]       addr,
  input  logic [7:0]             wdata,
  output logic [8*SEL_BYTES-1:0] flat
);
  for (genvar g = 0; g < SEL_BYTES; g++) begin : g_slot
    logic [7:0] slot_q;
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        slot_q <= '0;
      end else if (we && (addr == IDX_W'(g))) begin
        slot_q <= wdata;
      end
    end
    assign flat[8*g +: 8] = slot_q;
  end
endmodule

// File: rtl/swz_size_calc.sv
module swz_size_calc #(
  parameter int XCNT_W = 16,
  parameter int LINE_W = XCNT_W + 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [2:0]        bpc,
  input  logic [2:0]        nsrc,
  input  logic [2:0]        ndst,
  input  logic [XCNT_W-1:0] xcnt,
  input  logic              src_used,
  output logic [LINE_W-1:0] src_line,
  output logic [LINE_W-1:0] dst_line,
  output logic [31:0]       size_word
);
  logic [4:0] sbpp;
  logic [4:0] dbpp;

  assign sbpp = 5'(bpc) * 5'(nsrc);
  assign dbpp = 5'(bpc) * 5'(ndst);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_line  <= '0;
      dst_line  <= '0;
      size_word <= '0;
    end else if (load) begin
      src_line  <= src_used ? LINE_W'(xcnt) * LINE_W'(sbpp) : '0;
      dst_line  <= LINE_W'(xcnt) * LINE_W'(dbpp);
      size_word <= {16'h0000, 8'(dbpp - 5'd1), 8'(sbpp - 5'd1)};
    end
  end
endmodule

// File: rtl/swz_mask_gen.sv
module swz_mask_gen
  import swz_pkg::*;
#(
  parameter int XCNT_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [31:0]         fmt_word,
  input  logic [XCNT_W-1:0]   x_count,
  input  logic [31:0]         const_a,
  input  logic [31:0]         const_b,
  output logic                busy,
  output logic                done,
  output logic [31:0]         sel_w0,
  output logic [31:0]         sel_w1,
  output logic [31:0]         sel_w2,
  output logic [31:0]         sel_w3,
  output logic [XCNT_W+4:0]   src_line_bytes,
  output logic [XCNT_W+4:0]   dst_line_bytes,
  output logic [31:0]         size_word,
  output logic [31:0]         const_a_out,
  output logic [31:0]         const_b_out
);
  localparam int SEL_WORDS = 4;
  localparam int SEL_BYTES = SEL_WORDS * 4;
  localparam int IDX_W     = $clog2(SEL_BYTES);
  localparam int LINE_W    = XCNT_W + 5;

  logic [31:0]        fmt_q;
  logic [XCNT_W-1:0]  xcnt_q;
  fmt_fields_t        fld;
  logic               accept, step_en, fin;
  logic [IDX_W-1:0]   idx;
  logic [IDX_W:0]     comp;
  logic [2:0]         byte_i;
  logic [3:0]         cur_sel;
  logic [7:0]         code;
  logic               src_hit;
  logic               src_used_q;
  logic [8*SEL_BYTES-1:0] flat;

  assign fld     = decode_fmt(fmt_q);
  assign cur_sel = fmt_q[{comp[1:0], 2'b00} +: 4];

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q       <= '0;
      xcnt_q      <= '0;
      const_a_out <= '0;
      const_b_out <= '0;
      src_used_q  <= 1'b0;
    end else if (accept) begin
      fmt_q       <= fmt_word;
      xcnt_q      <= x_count;
      const_a_out <= const_a;
      const_b_out <= const_b;
      src_used_q  <= 1'b0;
    end else if (step_en && src_hit) begin
      src_used_q  <= 1'b1;
    end
  end

  swz_walker #(.SEL_BYTES(SEL_BYTES), .IDX_W(IDX_W)) u_walk (
    .clk(clk), .rst(rst), .start(start),
    .bpc(fld.bpc), .ndst(fld.ndst),
    .busy(busy), .accept(accept), .step_en(step_en), .fin(fin), .done(done),
    .idx(idx), .comp(comp), .byte_i(byte_i)
  );

  swz_byte_enc u_enc (
    .sel(cur_sel), .bpc(fld.bpc), .byte_i(byte_i),
    .code(code), .src_hit(src_hit)
  );

  swz_sel_store #(.SEL_BYTES(SEL_BYTES), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .clr(accept), .we(step_en),
    .addr(idx), .wdata(code), .flat(flat)
  );

  swz_size_calc #(.XCNT_W(XCNT_W), .LINE_W(LINE_W)) u_size (
    .clk(clk), .rst(rst), .load(fin),
    .bpc(fld.bpc), .nsrc(fld.nsrc), .ndst(fld.ndst),
    .xcnt(xcnt_q), .src_used(src_used_q),
    .src_line(src_line_bytes), .dst_line(dst_line_bytes), .size_word(size_word)
  );

  assign sel_w0 = flat[31:0];
  assign sel_w1 = flat[63:32];
  assign sel_w2 = flat[95:64];
  assign sel_w3 = flat[127:96];
endmodule

// File: rtl/swz_mask_gen_chk.sv
module swz_mask_gen_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [31:0] sel_w0,
  input logic [31:0] sel_w1,
  input logic [31:0] sel_w2,
  input logic [31:0] sel_w3,
  input logic [31:0] size_word
);
  function automatic logic codes_legal(input logic [127:0] t);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < 16; k++) begin
      if (!((t[8*k +: 8] < 8'h18) || (t[8*k +: 8] == 8'h80))) ok = 1'b0;
    end
    return ok;
  endfunction

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_start_takes_R9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(sel_w0) && $stable(sel_w1) &&
                           $stable(sel_w2) && $stable(sel_w3) && $stable(size_word)));

  assert_size_upper_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (size_word[31:16] == 16'h0000 && size_word[15:8] < 8'd16 && size_word[7:0] < 8'd16));

  assert_code_range_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> codes_legal({sel_w3, sel_w2, sel_w1, sel_w0}));
endmodule

bind swz_mask_gen swz_mask_gen_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .sel_w0(sel_w0), .sel_w1(sel_w1), .sel_w2(sel_w2), .sel_w3(sel_w3),
  .size_word(size_word)
);

// File: tb/tb_swz_mask_gen.sv
`timescale 1ns/1ps
module tb_swz_mask_gen;
  localparam int XCNT_W = 16;
  localparam int LINE_W = XCNT_W + 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst, start;
  logic [31:0]       fmt_word, const_a, const_b;
  logic [XCNT_W-1:0] x_count;
  logic              busy, done;
  logic [31:0]       sel_w0, sel_w1, sel_w2, sel_w3, size_word, const_a_out, const_b_out;
  logic [LINE_W-1:0] src_line_bytes, dst_line_bytes;

  swz_mask_gen #(.XCNT_W(XCNT_W)) dut (
    .clk(clk), .rst(rst), .start(start), .fmt_word(fmt_word), .x_count(x_count),
    .const_a(const_a), .const_b(const_b), .busy(busy), .done(done),
    .sel_w0(sel_w0), .sel_w1(sel_w1), .sel_w2(sel_w2), .sel_w3(sel_w3),
    .src_line_bytes(src_line_bytes), .dst_line_bytes(dst_line_bytes),
    .size_word(size_word), .const_a_out(const_a_out), .const_b_out(const_b_out)
  );

  int n_chk = 0;
  int n_fail = 0;
  int unsigned lcg = 32'h2468ace1;
  int cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog expired act=%0d exp<190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  function automatic int unsigned rnd_next(input int unsigned s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [31:0] f, input int k);
    int bpc, nd, comp, b, nib;
    bpc = int'(f[17:16]) + 1;
    nd  = int'(f[25:24]) + 1;
    if (k >= bpc * nd) return 8'h00;
    comp = k / bpc;
    b    = k % bpc;
    nib  = int'((f >> (4 * comp)) & 32'hf);
    if (nib < 4)  return 8'(nib * bpc + b);
    if (nib == 4) return 8'(16 + b);
    if (nib == 5) return 8'(20 + b);
    return 8'h80;
  endfunction

  function automatic string exp_tag(input logic [31:0] f, input int k);
    int bpc, nd, nib;
    bpc = int'(f[17:16]) + 1;
    nd  = int'(f[25:24]) + 1;
    if (k >= bpc * nd) return "R6 unused position";
    nib = int'((f >> (4 * (k / bpc))) & 32'hf);
    if (nib < 4) return "R3 source selector";
    if (nib < 6) return "R4 constant selector";
    return "R5 zero fill";
  endfunction

  task automatic check_results(input logic [31:0] f, input logic [15:0] xc,
                               input logic [31:0] ka, input logic [31:0] kb);
    int bpc, ns, nd, sb, db;
    bit used;
    logic [127:0] tbl;
    bpc = int'(f[17:16]) + 1;
    ns  = int'(f[21:20]) + 1;
    nd  = int'(f[25:24]) + 1;
    sb = bpc * ns;
    db = bpc * nd;
    used = 0;
    for (int c = 0; c < nd; c++) if (((f >> (4 * c)) & 32'hf) < 4) used = 1;
    tbl = {sel_w3, sel_w2, sel_w1, sel_w0};
    for (int k = 0; k < 16; k++)
      chk($sformatf("%s byte %0d fmt=%h", exp_tag(f, k), k, f), 64'(tbl[8*k +: 8]), 64'(exp_byte(f, k)));
    chk("R7 size word (fields per R2)", 64'(size_word), 64'({16'h0, 8'(db - 1), 8'(sb - 1)}));
    chk("R8 source line bytes", 64'(src_line_bytes), used ? 64'(xc) * 64'(sb) : 64'd0);
    chk("R8 destination line bytes", 64'(dst_line_bytes), 64'(xc) * 64'(db));
    chk("R10 constant a", 64'(const_a_out), 64'(ka));
    chk("R10 constant b", 64'(const_b_out), 64'(kb));
  endtask

  task automatic run_one(input logic [31:0] f, input logic [15:0] xc,
                         input logic [31:0] ka, input logic [31:0] kb, input bit meddle);
    @(negedge clk);
    fmt_word = f; x_count = xc; const_a = ka; const_b = kb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 busy after start", 64'(busy), 64'd1);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (meddle && i == 3) begin
        start = 1'b1; fmt_word = ~f; x_count = ~xc; const_a = ~ka; const_b = ~kb;
      end else begin
        start = 1'b0;
      end
    end
    chk("R9 done not early", 64'(done), 64'd0);
    @(negedge clk);
    chk("R9 done on cycle 17", 64'(done), 64'd1);
    check_results(f, xc, ka, kb);
    @(negedge clk);
    chk("R9 done single cycle", 64'(done), 64'd0);
    chk("R9 idle after done", 64'(busy), 64'd0);
  endtask

  initial begin
    logic [31:0] f, ka, kb, snap0, snap3, snapz;
    logic [15:0] xc;
    rst = 1'b1; start = 1'b0; fmt_word = '0; x_count = '0; const_a = '0; const_b = '0;
    repeat (3) @(negedge clk);
    chk("R1 done in reset", 64'(done), 64'd0);
    chk("R1 busy in reset", 64'(busy), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 table after reset", 64'(sel_w0 | sel_w1 | sel_w2 | sel_w3), 64'd0);
    chk("R1 counts after reset", 64'(src_line_bytes | dst_line_bytes), 64'd0);
    chk("R1 size after reset", 64'(size_word), 64'd0);
    chk("R1 idle after reset", 64'(busy | done), 64'd0);

    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 4; s++)
        for (int d = 0; d < 4; d++)
          for (int v = 0; v < 16; v++)
            for (int p = 0; p < 2; p++) begin
              lcg = rnd_next(lcg);
              f = lcg & 32'hfc_cc_0000;
              for (int j = 0; j < 4; j++)
                f[4*j +: 4] = (p == 0) ? 4'(v) : 4'((v + 5 * j) % 16);
              f[17:16] = 2'(c); f[21:20] = 2'(s); f[25:24] = 2'(d);
              lcg = rnd_next(lcg);
              xc = (v == 15) ? 16'hffff : lcg[23:8];
              ka = lcg ^ 32'h5a5a_0f0f;
              kb = ~lcg;
              run_one(f, xc, ka, kb, (v == 7 && p == 1));
            end

    snap0 = sel_w0; snap3 = sel_w3; snapz = size_word;
    @(negedge clk);
    fmt_word = 32'h0311_4321; x_count = 16'h1234; const_a = 32'h1; const_b = 32'h2;
    repeat (5) @(negedge clk);
    chk("R11 word 0 holds while idle", 64'(sel_w0), 64'(snap0));
    chk("R11 word 3 holds while idle", 64'(sel_w3), 64'(snap3));
    chk("R11 size word holds while idle", 64'(size_word), 64'(snapz));
    chk("R11 no done without start", 64'(done), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule